// File: doc/BRIEF.md
# Saturating Shift-and-Clamp Execution Unit

This unit executes the saturate family of a 32-bit instruction set. Each cycle it can accept one instruction word together with the value of its source register. It decodes the word and returns three things: the destination register index, a 32-bit result, and a sticky saturation flag. Any word outside the family is marked undefined.

The word forms work in two steps. First they apply an optional immediate shift, either logical left or arithmetic right. Then they clamp the shifted value to a signed or unsigned range whose width comes from the instruction. The dual-halfword forms have no shift. They clamp each signed 16-bit half of the operand on its own and pack the two results together. The saturation flag collects clamp events until either a dedicated clear input or reset returns it to zero.

Condition evaluation, the register file and hazard handling stay with the surrounding pipeline. The unit treats every word it receives as unconditionally executed.

Top module: `sat_clamp_unit`

## Requirements
- R1: The unit recognises four patterns and no others:
  - signed word: bits [27:21] = 0110101 and bits [5:4] = 01;
  - unsigned word: bits [27:21] = 0110111 and bits [5:4] = 01;
  - signed halfword: bits [27:20] = 01101010 and bits [11:4] = 11110011;
  - unsigned halfword: bits [27:20] = 01101110 and bits [11:4] = 11110011.
- R2: Bits [31:28] have no effect on decode or on the result.
- R3: In a word form, bits [3:0] name the source, bits [15:12] give the destination index, bits [11:7] give the shift amount and bits [20:16] give the range width k. When bit 6 is 0, the operand is shifted left by the amount, and an amount of 0 leaves it unchanged.
- R4: In a word form with bit 6 = 1, the shift is arithmetic right. An encoded amount of 0 means a shift by 32, which yields 32 copies of the operand's sign bit.
- R5: Signed forms clamp to the range -2^k through 2^k-1. The value is compared as a signed 32-bit number, first against the maximum and then against the minimum. A value inside the range passes through unchanged.
- R6: Unsigned forms clamp to the range 0 through 2^k-1.
- R7: Halfword forms take k from bits [19:16]. They clamp the sign-extended bits [15:0] into result bits [15:0] and the signed bits [31:16] into result bits [31:16], each half on its own.
- R8: Any clamp, including a clamp in either half, sets the flag. A result that is not clamped never clears it.
- R9: Reset drives the flag to 0. When the clear input is high, the flag goes to 0 on that cycle's edge. A clamp accepted on the same edge as the clear wins, and the flag ends up set.
- R10: Result, destination index and flag are registered. The output valid is high exactly one cycle after an input valid.
- R11: An unrecognised word raises the undefined output in the output cycle and leaves the result, destination index and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| operand | input | 32 | Source register value |
| q_clear | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result of the previous cycle's instruction is present |
| out_rd | output | 4 | Destination register index |
| out_result | output | 32 | Clamped result |
| out_q | output | 1 | Sticky saturation flag |
| out_undef | output | 1 | Previous word was not in the family |

## Verification
The hardest case to reach from the ports is the arithmetic-right shift by 32 when it meets the widest ranges. At k = 31 the signed range admits every value and the unsigned range cuts off only negatives, so a wrong shift fill or a wrong bound shows up in just a few operand values. The stimulus sweeps every k for both shift types, across shift amounts 0, 1 and values near 8, 16 and 31, and across operands at the sign and half-word boundaries. The clear input is pulsed on a fixed fraction of those instructions, which also exercises the case where a clear and a clamp land on the same edge.

// File: rtl/sat_clamp_unit.sv
module sat_clamp_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic [31:0] operand,
  input  logic        q_clear,
  output logic        out_valid,
  output logic [3:0]  out_rd,
  output logic [31:0] out_result,
  output logic        out_q,
  output logic        out_undef
);

  function automatic logic [32:0] clamp_word(input logic [31:0] v, input logic [4:0] k, input logic uns);
    logic signed [32:0] hi, lo, vx;
    hi = (33'sd1 <<< k) - 33'sd1;
    lo = uns ? 33'sd0 : -(33'sd1 <<< k);
    vx = $signed({v[31], v});
    if (vx > hi) return {1'b1, hi[31:0]};
    else if (vx < lo) return {1'b1, lo[31:0]};
    else return {1'b0, v};
  endfunction

  function automatic logic [16:0] clamp_half(input logic [15:0] v, input logic [3:0] k, input logic uns);
    logic signed [16:0] hi, lo, vx;
    hi = (17'sd1 <<< k) - 17'sd1;
    lo = uns ? 17'sd0 : -(17'sd1 <<< k);
    vx = $signed({v[15], v});
    if (vx > hi) return {1'b1, hi[15:0]};
    else if (vx < lo) return {1'b1, lo[15:0]};
    else return {1'b0, v};
  endfunction

  wire is_word_s = (instr[27:21] == 7'b0110101) && (instr[5:4] == 2'b01);
  wire is_word_u = (instr[27:21] == 7'b0110111) && (instr[5:4] == 2'b01);
  wire is_half_s = (instr[27:20] == 8'b01101010) && (instr[11:4] == 8'hF3);
  wire is_half_u = (instr[27:20] == 8'b01101110) && (instr[11:4] == 8'hF3);
  wire is_word   = is_word_s | is_word_u;
  wire is_half   = is_half_s | is_half_u;
  wire matched   = is_word | is_half;

  wire [4:0] sh_amt = instr[11:7];
  wire       sh_asr = instr[6];

  logic [31:0] shifted;
  always_comb begin
    if (!sh_asr)
      shifted = operand << sh_amt;
    else if (sh_amt == 5'd0)
      shifted = {32{operand[31]}};
    else
      shifted = $unsigned($signed(operand) >>> sh_amt);
  end

  wire [32:0] word_res = clamp_word(shifted, instr[20:16], is_word_u);
  wire [16:0] lo_res   = clamp_half(operand[15:0], instr[19:16], is_half_u);
  wire [16:0] hi_res   = clamp_half(operand[31:16], instr[19:16], is_half_u);

  wire [31:0] next_res = is_word ? word_res[31:0] : {hi_res[15:0], lo_res[15:0]};
  wire        next_sat = is_word ? word_res[32] : (lo_res[16] | hi_res[16]);
  wire        take     = in_valid & matched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_undef  <= 1'b0;
      out_rd     <= 4'd0;
      out_result <= 32'd0;
      out_q      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_undef <= in_valid & ~matched;
      out_q     <= (out_q & ~q_clear) | (take & next_sat);
      if (take) begin
        out_rd     <= instr[15:12];
        out_result <= next_res;
      end
    end
  end

endmodule

module sat_clamp_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic [31:0] operand,
  input logic        q_clear,
  input logic        out_valid,
  input logic [3:0]  out_rd,
  input logic [31:0] out_result,
  input logic        out_q,
  input logic        out_undef
);

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_q_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && !q_clear) |=> out_q);

  assert_clear_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_clear && !in_valid) |=> !out_q);

  assert_undef_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> out_valid);

  assert_undef_holds_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_undef) |-> ($stable(out_result) && $stable(out_rd)));

endmodule

bind sat_clamp_unit sat_clamp_unit_chk u_chk (.*);

// File: tb/sim_sat_clamp_unit.sv
module sim_sat_clamp_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] operand = '0;
  logic q_clear = 1'b0;
  logic out_valid, out_q, out_undef;
  logic [3:0] out_rd;
  logic [31:0] out_result;

  int checks = 0;
  int errors = 0;
  logic q_model = 1'b0;
  logic [31:0] last_res = '0;
  logic [3:0] last_rd = '0;
  int n = 0;

  always #4 clk = ~clk;

  sat_clamp_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .operand(operand), .q_clear(q_clear), .out_valid(out_valid), .out_rd(out_rd),
    .out_result(out_result), .out_q(out_q), .out_undef(out_undef));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [32:0] model_clamp(input longint v, input int k, input bit uns);
    longint hi, lo;
    hi = (64'sd1 << k) - 1;
    lo = uns ? 0 : -(64'sd1 << k);
    if (v > hi) return {1'b1, hi[31:0]};
    if (v < lo) return {1'b1, lo[31:0]};
    return {1'b0, v[31:0]};
  endfunction

  task automatic run_op(input logic [31:0] w, input logic [31:0] op, input bit clr,
                        input bit defined, input logic [32:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; instr = w; operand = op; q_clear = clr;
    @(negedge clk);
    in_valid = 1'b0; q_clear = 1'b0;
    q_model = (q_model & ~clr) | (defined & exp[32]);
    check("R10 valid", {31'd0, out_valid}, 32'd1);
    check("R1 undef", {31'd0, out_undef}, {31'd0, !defined});
    if (defined) begin
      last_res = exp[31:0];
      last_rd = w[15:12];
      check(tag, out_result, exp[31:0]);
    end else begin
      check("R11 result held", out_result, last_res);
    end
    check("R11 rd", {28'd0, out_rd}, {28'd0, last_rd});
    check("R8 R9 q", {31'd0, out_q}, {31'd0, q_model});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] shs [7] = '{5'd0, 5'd1, 5'd7, 5'd8, 5'd15, 5'd16, 5'd31};
    logic [31:0] ops [8] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF,
                            32'h00008000, 32'hFFFF7FFF, 32'h0001FFFF};
    repeat (3) @(negedge clk);
    check("R9 reset q", {31'd0, out_q}, 32'd0);
    check("R10 reset valid", {31'd0, out_valid}, 32'd0);
    check("R10 reset result", out_result, 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < 32; k++)
      for (int t = 0; t < 2; t++)
        for (int si = 0; si < 7; si++)
          for (int oi = 0; oi < 8; oi++)
            for (int u = 0; u < 2; u++) begin
              logic [31:0] w;
              longint v;
              logic [31:0] op;
              string tag;
              op = ops[oi] ^ {27'd0, shs[si]} ^ (oi == 0 ? 32'h0 : 32'h0);
              w = {4'(n), 4'b0110, 1'b1, 1'(u), 1'b1, 5'(k), 4'(n + 3),
                   shs[si], 1'(t), 2'b01, 4'(n)};
              if (t == 0) v = longint'($signed(32'(op << shs[si])));
              else if (shs[si] == 0) v = op[31] ? -1 : 0;
              else v = longint'($signed(op)) >>> shs[si];
              if (t == 1) tag = "R4 asr";
              else if (shs[si] != 0) tag = "R3 lsl";
              else tag = u ? "R6 unsigned" : "R5 signed";
              run_op(w, op, (n % 7) == 3, 1'b1, model_clamp(v, k, u), tag);
              n++;
            end

    for (int k = 0; k < 16; k++)
      for (int oi = 0; oi < 8; oi++)
        for (int u = 0; u < 2; u++) begin
          logic [32:0] lo, hi;
          logic [31:0] op;
          logic [31:0] w;
          op = ops[oi] ^ (32'h00010003 * k);
          w = {4'(n * 5), 4'b0110, 1'b1, 1'(u), 2'b10, 4'(k), 4'(n), 8'hF3, 4'(n + 1)};
          lo = model_clamp(longint'($signed(op[15:0])), k, u);
          hi = model_clamp(longint'($signed(op[31:16])), k, u);
          run_op(w, op, (n % 5) == 2, 1'b1,
                 {lo[32] | hi[32], hi[15:0], lo[15:0]}, "R7 halfword");
          n++;
        end

    run_op(32'hE6A00000, 32'h12345678, 1'b0, 1'b0, 33'd0, "R1 bad low bits");
    run_op(32'hE6A00F00, 32'h12345678, 1'b0, 1'b0, 33'd0, "R1 bad half");
    run_op(32'h00000000, 32'h0, 1'b0, 1'b0, 33'd0, "R1 zero word");
    run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 33'd0, "R1 ones word");
    run_op(32'h06E1A010, 32'h7FFFFFFF, 1'b0, 1'b1, {1'b1, 32'h1}, "R2 cond zero");
    run_op(32'hF6E1B010, 32'h7FFFFFFF, 1'b0, 1'b1, {1'b1, 32'h1}, "R2 cond ones");

    @(negedge clk);
    q_clear = 1'b1;
    @(negedge clk);
    q_clear = 1'b0;
    q_model = 1'b0;
    check("R9 clear", {31'd0, out_q}, 32'd0);
    check("R10 idle", {31'd0, out_valid}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule